// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block picks the two ALU operands for the instruction in the execute stage of a five-stage pipeline. Each operand comes from one of three places: the value read from the register file during decode, the final result of the instruction now in write-back, or the ALU result of the instruction now in the memory stage. The choice depends on the execute-stage source register numbers and the destinations of the two older instructions. If both older instructions write the needed register, the memory-stage instruction is newer, so its value is used.

The unit is purely combinational. Each operand has a 2-bit select output (00 register file, 01 write-back, 10 memory stage), so the surrounding control and the bench can see which path was taken. Instructions that write no register carry destination 0 down the pipe, and destination 0 never forwards. A load in the memory stage has only an address on its ALU-result bus, so that bus is never forwarded. Resolving a load followed at once by a dependent instruction is left to the stall logic upstream.

Because the block is a combinational selector between pipeline registers, it has no valid/ready handshake. Its inputs are the existing stage registers, and its outputs are used in the same cycle.

Top module: `exfwd_unit`

## Requirements
- R1: The first source register number is instruction bits 25:21 and the second is bits 20:16. No other instruction bit affects any output.
- R2: Select A is 2'b10 and operand A equals the memory-stage ALU result when the first source equals the memory-stage destination, that destination is nonzero, and the memory-stage opcode is not the load code 6'b100011.
- R3: Select A is 2'b01 and operand A equals the write-back result when the first source equals the write-back destination, that destination is nonzero, and the R2 condition does not hold.
- R4: Operand B and select B follow the R2, R3 and R6 rules using the second source field.
- R5: When the memory-stage and write-back conditions both hold for an operand, that operand takes the memory-stage value (select 2'b10).
- R6: When neither condition holds, the select is 2'b00 and the operand is the register-file value for that side.
- R7: While the memory-stage opcode equals 6'b100011, neither select is 2'b10. An operand that also matches the write-back destination takes the write-back value; otherwise it takes the register-file value.
- R8: A source field of 0 always gives select 2'b00 and the register-file value, even when a stage destination is 0.
- R9: Each select is always one of 2'b00, 2'b01 or 2'b10, and the outputs follow the inputs with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_instr | input | 32 | Instruction word held in the execute stage |
| ex_rf_a | input | 32 | First operand read from the register file in decode |
| ex_rf_b | input | 32 | Second operand read from the register file in decode |
| mem_dst | input | 5 | Destination register of the memory-stage instruction (0 if none) |
| mem_op | input | 6 | Opcode of the memory-stage instruction |
| mem_alu | input | 32 | ALU result of the memory-stage instruction |
| wb_dst | input | 5 | Destination register of the write-back instruction (0 if none) |
| wb_result | input | 32 | Final result (ALU or load data) of the write-back instruction |
| opnd_a | output | 32 | Selected ALU operand A |
| opnd_b | output | 32 | Selected ALU operand B |
| sel_a | output | 2 | Source of operand A: 00 register file, 01 write-back, 10 memory stage |
| sel_b | output | 2 | Source of operand B, same encoding |

## Verification
Every output is a function of the present inputs, so each result is due in the same cycle as its stimulus, after zero clock edges. The bench changes inputs just after a rising edge and compares at the following falling edge, half a period later, when no register sits on any path. The sweep covers every combination of source, destination and load status drawn from a register set that includes 0, 1, 17 and 31. It then repeats selected cases with every bit outside the two source fields inverted, to show that only the source fields matter.

// File: rtl/exfwd_pkg.sv
package exfwd_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_MEM = 2'b10
  } src_sel_e;

  localparam int NUM_OPND = 2;
endpackage

// File: rtl/exfwd_decode.sv
module exfwd_decode
  import exfwd_pkg::*;
#(
  parameter int IW       = 32,
  parameter int RW       = 5,
  parameter int SRC1_LSB = 21,
  parameter int SRC2_LSB = 16
) (
  input  logic [IW-1:0]                instr,
  output logic [NUM_OPND-1:0][RW-1:0]  src
);
  localparam int LSB0 = SRC1_LSB;
  localparam int LSB1 = SRC2_LSB;

  assign src[0] = instr[LSB0 +: RW];
  assign src[1] = instr[LSB1 +: RW];
endmodule

// File: rtl/exfwd_match.sv
module exfwd_match
  import exfwd_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic [RW-1:0] src,
  input  logic [RW-1:0] mem_dst,
  input  logic          mem_is_load,
  input  logic [RW-1:0] wb_dst,
  output src_sel_e      sel
);
  localparam logic [RW-1:0] ZERO_REG = '0;

  logic mem_hit;
  logic wb_hit;

  // The memory stage of a load holds only an address, which must not be forwarded.
  assign mem_hit = (src == mem_dst) && (mem_dst != ZERO_REG) && !mem_is_load;
  assign wb_hit  = (src == wb_dst) && (wb_dst != ZERO_REG);

  // The nearer (newer) producer wins.
  always_comb begin
    if (mem_hit)     sel = SRC_MEM;
    else if (wb_hit) sel = SRC_WB;
    else             sel = SRC_RF;
  end
endmodule

// File: rtl/exfwd_mux.sv
module exfwd_mux
  import exfwd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  src_sel_e        sel,
  input  logic [XLEN-1:0] rf_val,
  input  logic [XLEN-1:0] wb_val,
  input  logic [XLEN-1:0] mem_val,
  output logic [XLEN-1:0] out_val
);
  always_comb begin
    unique case (sel)
      SRC_MEM: out_val = mem_val;
      SRC_WB:  out_val = wb_val;
      default: out_val = rf_val;
    endcase
  end
endmodule

// File: rtl/exfwd_unit.sv
module exfwd_unit
  import exfwd_pkg::*;
#(
  parameter int             XLEN     = 32,
  parameter int             IW       = 32,
  parameter int             RW       = 5,
  parameter int             OPW      = 6,
  parameter int             SRC1_LSB = 21,
  parameter int             SRC2_LSB = 16,
  parameter logic [OPW-1:0] LOAD_OP  = 6'b100011
) (
  input  logic [IW-1:0]   ex_instr,
  input  logic [XLEN-1:0] ex_rf_a,
  input  logic [XLEN-1:0] ex_rf_b,
  input  logic [RW-1:0]   mem_dst,
  input  logic [OPW-1:0]  mem_op,
  input  logic [XLEN-1:0] mem_alu,
  input  logic [RW-1:0]   wb_dst,
  input  logic [XLEN-1:0] wb_result,
  output logic [XLEN-1:0] opnd_a,
  output logic [XLEN-1:0] opnd_b,
  output logic [1:0]      sel_a,
  output logic [1:0]      sel_b
);
  logic [NUM_OPND-1:0][RW-1:0]   src;
  logic [NUM_OPND-1:0][XLEN-1:0] rf_vals;
  logic [NUM_OPND-1:0][XLEN-1:0] out_vals;
  src_sel_e                      sels [NUM_OPND];
  logic                          mem_is_load;

  assign mem_is_load = (mem_op == LOAD_OP);
  assign rf_vals[0]  = ex_rf_a;
  assign rf_vals[1]  = ex_rf_b;

  exfwd_decode #(
    .IW(IW), .RW(RW), .SRC1_LSB(SRC1_LSB), .SRC2_LSB(SRC2_LSB)
  ) u_decode (
    .instr (ex_instr),
    .src   (src)
  );

  for (genvar k = 0; k < NUM_OPND; k++) begin : g_opnd
    exfwd_match #(.RW(RW)) u_match (
      .src         (src[k]),
      .mem_dst     (mem_dst),
      .mem_is_load (mem_is_load),
      .wb_dst      (wb_dst),
      .sel         (sels[k])
    );

    exfwd_mux #(.XLEN(XLEN)) u_mux (
      .sel     (sels[k]),
      .rf_val  (rf_vals[k]),
      .wb_val  (wb_result),
      .mem_val (mem_alu),
      .out_val (out_vals[k])
    );
  end

  assign opnd_a = out_vals[0];
  assign opnd_b = out_vals[1];
  assign sel_a  = sels[0];
  assign sel_b  = sels[1];
endmodule

// File: rtl/exfwd_unit_chk.sv
module exfwd_unit_chk #(
  parameter int             XLEN     = 32,
  parameter int             IW       = 32,
  parameter int             RW       = 5,
  parameter int             OPW      = 6,
  parameter int             SRC1_LSB = 21,
  parameter int             SRC2_LSB = 16,
  parameter logic [OPW-1:0] LOAD_OP  = 6'b100011
) (
  input logic [IW-1:0]   ex_instr,
  input logic [XLEN-1:0] ex_rf_a,
  input logic [XLEN-1:0] ex_rf_b,
  input logic [RW-1:0]   mem_dst,
  input logic [OPW-1:0]  mem_op,
  input logic [XLEN-1:0] mem_alu,
  input logic [RW-1:0]   wb_dst,
  input logic [XLEN-1:0] wb_result,
  input logic [XLEN-1:0] opnd_a,
  input logic [XLEN-1:0] opnd_b,
  input logic [1:0]      sel_a,
  input logic [1:0]      sel_b
);
  logic [RW-1:0] s1;
  logic [RW-1:0] s2;
  logic          ld;
  logic          known;

  assign s1    = ex_instr[SRC1_LSB +: RW];
  assign s2    = ex_instr[SRC2_LSB +: RW];
  assign ld    = (mem_op == LOAD_OP);
  assign known = !$isunknown({ex_instr, ex_rf_a, ex_rf_b, mem_dst, mem_op,
                              mem_alu, wb_dst, wb_result, opnd_a, opnd_b, sel_a, sel_b});

  always_comb begin
    if (known) begin
      assert_a_mem_cond_R2: assert (sel_a != 2'b10 || (s1 == mem_dst && mem_dst != '0 && !ld));
      assert_a_mem_value_R2: assert (sel_a != 2'b10 || opnd_a == mem_alu);
      assert_a_wb_cond_R3: assert (sel_a != 2'b01 || (s1 == wb_dst && wb_dst != '0));
      assert_a_wb_value_R3: assert (sel_a != 2'b01 || opnd_a == wb_result);
      assert_b_mem_cond_R4: assert (sel_b != 2'b10 || (s2 == mem_dst && mem_dst != '0 && !ld));
      assert_b_wb_cond_R4: assert (sel_b != 2'b01 || (s2 == wb_dst && wb_dst != '0));
      assert_mem_wins_R5: assert (!(s1 == mem_dst && mem_dst != '0 && !ld) || sel_a == 2'b10);
      assert_rf_value_R6: assert (sel_a != 2'b00 || opnd_a == ex_rf_a);
      assert_rf_value_b_R6: assert (sel_b != 2'b00 || opnd_b == ex_rf_b);
      assert_load_blocked_R7: assert (!ld || (sel_a != 2'b10 && sel_b != 2'b10));
      assert_zero_src_R8: assert ((s1 != '0 || sel_a == 2'b00) && (s2 != '0 || sel_b == 2'b00));
      assert_sel_legal_R9: assert (sel_a != 2'b11 && sel_b != 2'b11);
    end
  end
endmodule

bind exfwd_unit exfwd_unit_chk #(
  .XLEN(XLEN), .IW(IW), .RW(RW), .OPW(OPW),
  .SRC1_LSB(SRC1_LSB), .SRC2_LSB(SRC2_LSB), .LOAD_OP(LOAD_OP)
) u_chk (
  .ex_instr(ex_instr), .ex_rf_a(ex_rf_a), .ex_rf_b(ex_rf_b),
  .mem_dst(mem_dst), .mem_op(mem_op), .mem_alu(mem_alu),
  .wb_dst(wb_dst), .wb_result(wb_result),
  .opnd_a(opnd_a), .opnd_b(opnd_b), .sel_a(sel_a), .sel_b(sel_b)
);

// File: tb/exfwd_unit_test.sv
`timescale 1ns/1ps
module exfwd_unit_test;
  logic        clk = 1'b0;
  logic [31:0] ex_instr = '0;
  logic [31:0] ex_rf_a = '0;
  logic [31:0] ex_rf_b = '0;
  logic [4:0]  mem_dst = '0;
  logic [5:0]  mem_op = '0;
  logic [31:0] mem_alu = '0;
  logic [4:0]  wb_dst = '0;
  logic [31:0] wb_result = '0;
  logic [31:0] opnd_a;
  logic [31:0] opnd_b;
  logic [1:0]  sel_a;
  logic [1:0]  sel_b;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  exfwd_unit uut (
    .ex_instr(ex_instr), .ex_rf_a(ex_rf_a), .ex_rf_b(ex_rf_b),
    .mem_dst(mem_dst), .mem_op(mem_op), .mem_alu(mem_alu),
    .wb_dst(wb_dst), .wb_result(wb_result),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .sel_a(sel_a), .sel_b(sel_b)
  );

  function automatic logic [1:0] want_sel(logic [4:0] s, logic [4:0] md, bit ld, logic [4:0] wd);
    if (s == md && md != 0 && !ld) return 2'b10;
    if (s == wd && wd != 0)        return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [31:0] want_val(logic [1:0] sl, logic [31:0] rf);
    case (sl)
      2'b10:   return mem_alu;
      2'b01:   return wb_result;
      default: return rf;
    endcase
  endfunction

  function automatic string tag_for(logic [4:0] s, logic [4:0] md, bit ld, logic [4:0] wd, bit side_b);
    if (s == md && md != 0 && !ld && s == wd) return "R5";
    if (ld && s == md && md != 0)             return "R7";
    if (s == 0)                               return "R8";
    if (side_b)                               return "R4";
    if (s == md && md != 0)                   return "R2";
    if (s == wd && wd != 0)                   return "R3";
    return "R6";
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply(logic [4:0] s1, logic [4:0] s2, logic [4:0] md, bit ld,
                       logic [4:0] wd, int it, bit invert_other, string force_tag);
    logic [1:0] ea, eb;
    logic [31:0] other;
    string ta, tb;
    @(posedge clk);
    other     = invert_other ? 32'hFC00_FFFF : (32'(it) * 32'h0400_0123) & 32'hFC00_FFFF;
    ex_instr  = other | {6'b0, s1, s2, 16'b0};
    ex_rf_a   = 32'h1111_0000 + 32'(it);
    ex_rf_b   = 32'h2222_0000 + 32'(it);
    mem_alu   = 32'h3333_0000 + 32'(it);
    wb_result = 32'h4444_0000 + 32'(it);
    mem_dst   = md;
    wb_dst    = wd;
    mem_op    = ld ? 6'b100011 : ((it % 3 == 0) ? 6'b101011 : ((it % 3 == 1) ? 6'b100010 : 6'b000000));
    @(negedge clk);
    ea = want_sel(s1, md, ld, wd);
    eb = want_sel(s2, md, ld, wd);
    ta = (force_tag != "") ? force_tag : tag_for(s1, md, ld, wd, 1'b0);
    tb = (force_tag != "") ? force_tag : tag_for(s2, md, ld, wd, 1'b1);
    check(ta, "sel_a", {30'b0, sel_a}, {30'b0, ea});
    check(ta, "opnd_a", opnd_a, want_val(ea, ex_rf_a));
    check(tb, "sel_b", {30'b0, sel_b}, {30'b0, eb});
    check(tb, "opnd_b", opnd_b, want_val(eb, ex_rf_b));
    check("R9", "sel_legal", {31'b0, (sel_a == 2'b11) || (sel_b == 2'b11)}, 32'd0);
  endtask

  initial begin
    logic [4:0] regs [4];
    int it;
    regs[0] = 5'd0; regs[1] = 5'd1; regs[2] = 5'd17; regs[3] = 5'd31;
    it = 0;
    // All-zero inputs: register-file path, zero outputs.
    @(negedge clk);
    check("R6", "idle sel_a", {30'b0, sel_a}, 32'd0);
    check("R6", "idle opnd_a", opnd_a, 32'd0);
    for (int ia = 0; ia < 4; ia++)
      for (int ib = 0; ib < 4; ib++)
        for (int im = 0; im < 4; im++)
          for (int iw = 0; iw < 4; iw++)
            for (int il = 0; il < 2; il++) begin
              apply(regs[ia], regs[ib], regs[im], il[0], regs[iw], it, 1'b0, "");
              it++;
            end
    // Bits outside the source fields must not matter.
    for (int k = 0; k < 4; k++) begin
      apply(regs[k], regs[3 - k], regs[k], 1'b0, regs[3 - k], it, 1'b1, "R1");
      it++;
      apply(regs[k], regs[k], regs[3 - k], 1'b0, regs[k], it, 1'b0, "R1");
      it++;
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule